// File: doc/BRIEF.md
# Dual-Core Channelized Mailbox

This block lets two processors signal each other through a pair of 32-bit mailbox words, one word owned by each core. A core posts an event to its peer by ORing bits into the peer's word. The owner acknowledges by clearing exactly the bits it observed. Each word has a fixed layout. The top nibble holds four signal triggers and the next nibble holds four data triggers. The low 24 bits are a payload shared by all data events. Channel 0 sits at the top bit of each nibble, and higher channels follow downward.

A send front end per core turns a request (channel, mode, byte count, payload) into a single set-bits write and returns a status one cycle later. A receive front end per core captures its own word when it becomes non-zero. It presents the decoded per-channel events one at a time on a valid/ready handshake and then clears the captured bits. Each core chooses how many receive channels are enabled, and the enabled channels always start at channel 0. The interrupt toward a core stays high while any bit of its word is set.

Top module: `ipc_mbox_top`

## Requirements
- R1: A signal-mode send from core k on channel n (0..3) sets only bit 31-n of the word owned by core 1-k. Status 0 (OK) is returned on send_status one cycle after the request, with send_done high for that cycle.
- R2: A data-mode send with size 3 on channel n ORs bit 27-n and the 24-bit payload into bits 23..0 of the peer word in the same write, and returns status 0.
- R3: A send with channel index 4 or more returns status 1 (bad channel) and leaves the peer word unchanged.
- R4: A data-mode send whose size is not 3 returns status 2 (bad size) and leaves the peer word unchanged. A signal-mode send ignores the size.
- R5: irq[k] is high exactly when core k's word is non-zero. It stays high while events are still pending.
- R6: Received events come out one per handshake in ascending channel order. rx_kind is 1 for data, with rx_payload set to bits 23..0, and 0 for signal, with rx_payload set to 0. A channel with both bits set gives a single data event.
- R7: Channels that are not enabled produce no event, but their bits are still cleared along with the captured word.
- R8: Writing cfg_rx_count = N with N from 1 to 4 enables channels 0..N-1. Other values are ignored. After reset no channel is enabled.
- R9: The clear is applied only after every event of the captured word is consumed, and it removes only the captured bits. Bits set in the meantime survive and are reported afterwards.
- R10: When a set and a clear hit the same word in one cycle, the set bits remain set.
- R11: After reset both words are 0, both interrupts are low, and rx_valid and send_done are low.
- R12: While rx_valid is high and rx_ready is low, the event outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_valid | input | 2 | Send request per core |
| send_chan | input | 2x3 | Requested channel index per core |
| send_data_mode | input | 2 | 1 = data send, 0 = signal send |
| send_size | input | 2x3 | Byte count of a data send |
| send_payload | input | 2x24 | Payload of a data send |
| send_done | output | 2 | Status valid, one cycle after a request |
| send_status | output | 2x2 | 0 OK, 1 bad channel, 2 bad size |
| cfg_we | input | 2 | Write of the receive channel count |
| cfg_rx_count | input | 2x3 | Number of enabled receive channels |
| rx_valid | output | 2 | Decoded event available |
| rx_ready | input | 2 | Event accepted by the core |
| rx_chan | output | 2x2 | Channel of the presented event |
| rx_kind | output | 2 | 1 data event, 0 signal event |
| rx_payload | output | 2x24 | Payload of a data event, else 0 |
| word_rd | output | 2x32 | Read of each core's own mailbox word |
| irq | output | 2 | Interrupt toward each core |

## Verification
Random single sends cover every channel index from 0 to 5, both modes, sizes that are mostly 3 with some other values, and random enable counts. This separates accepted writes, both rejection paths and masked channels. A directed burst loads several channels into a word while the receiver stalls. It shows the ascending order of events, data taking precedence over signal on a channel, payload ORing, and the survival of bits set after capture. A send placed in the very cycle of the clear separates set-priority from clear-priority. Out-of-range counts written to the configuration check that the enable mask is left unchanged.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
    localparam int unsigned NCORE = 2;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_BAD_CHAN = 2'd1,
        ST_BAD_SIZE = 2'd2
    } send_status_e;

    typedef enum logic {
        EV_SIGNAL = 1'b0,
        EV_DATA   = 1'b1
    } ev_kind_e;
endpackage

// File: rtl/ipc_mbox_packer.sv
module ipc_mbox_packer
    import ipc_mbox_pkg::*;
#(
    parameter int CHANNELS = 4,
    parameter int WORD_W   = 32,
    parameter int CIDX_W   = 3,
    localparam int PAY_W   = WORD_W - 2 * CHANNELS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CIDX_W-1:0] chan_i,
    input  logic              data_i,
    input  logic [CIDX_W-1:0] size_i,
    input  logic [PAY_W-1:0]  payload_i,
    output logic [WORD_W-1:0] set_o,
    output logic              done_o,
    output logic [1:0]        status_o
);
    localparam int PAY_BYTES = PAY_W / 8;
    localparam int DAT_TOP   = WORD_W - 1 - CHANNELS;

    typedef struct packed {
        logic         done;
        send_status_e status;
    } pk_state_t;

    pk_state_t    st_q, st_d;
    send_status_e verdict;
    logic [WORD_W-1:0] word_img;

    always_comb begin
        verdict  = ST_OK;
        word_img = '0;
        if (int'(chan_i) >= CHANNELS) begin
            verdict = ST_BAD_CHAN;
        end else if (data_i && (int'(size_i) != PAY_BYTES)) begin
            verdict = ST_BAD_SIZE;
        end else begin
            for (int i = 0; i < CHANNELS; i++) begin
                if (int'(chan_i) == i) begin
                    if (data_i) word_img[DAT_TOP - i] = 1'b1;
                    else        word_img[WORD_W - 1 - i] = 1'b1;
                end
            end
            if (data_i) word_img[PAY_W-1:0] = payload_i;
        end
        set_o = (valid_i && verdict == ST_OK) ? word_img : '0;

        st_d      = st_q;
        st_d.done = valid_i;
        if (valid_i) st_d.status = verdict;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{done: 1'b0, status: ST_OK};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o   = st_q.done;
    assign status_o = st_q.status;

    // R3 / R4: a request that reports a rejection must not have written anything
    a_r3_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (int'(chan_i) >= CHANNELS) |-> set_o == '0);
endmodule

// File: rtl/ipc_mbox_word.sv
module ipc_mbox_word #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_i,
    input  logic [WORD_W-1:0] clr_i,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } wd_state_t;

    wd_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.word = (st_q.word & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;

    // R10: bits set in a cycle are present afterwards, even under a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (word_o & $past(set_i)) == $past(set_i));

    // R9: bits neither set nor cleared keep their value
    a_r9_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((word_o ^ $past(word_o)) & ~($past(set_i) | $past(clr_i))) == '0);
endmodule

// File: rtl/ipc_mbox_rx.sv
module ipc_mbox_rx
    import ipc_mbox_pkg::*;
#(
    parameter int CHANNELS = 4,
    parameter int WORD_W   = 32,
    parameter int CIDX_W   = 3,
    localparam int PAY_W   = WORD_W - 2 * CHANNELS,
    localparam int CH_W    = $clog2(CHANNELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              cfg_we_i,
    input  logic [CIDX_W-1:0] cfg_count_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              kind_o,
    output logic [PAY_W-1:0]  payload_o,
    output logic [WORD_W-1:0] clr_o
);
    localparam int DAT_TOP = WORD_W - 1 - CHANNELS;

    typedef struct packed {
        logic                busy;
        logic [WORD_W-1:0]   hold;
        logic [CHANNELS-1:0] pend;
        logic [CHANNELS-1:0] mask;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic [CH_W-1:0] sel;
    logic            sel_data;

    always_comb begin
        sel      = '0;
        sel_data = 1'b0;
        for (int i = CHANNELS - 1; i >= 0; i--) begin
            if (st_q.pend[i]) sel = CH_W'(i);
        end
        for (int i = 0; i < CHANNELS; i++) begin
            if (int'(sel) == i) sel_data = st_q.hold[DAT_TOP - i];
        end

        valid_o   = st_q.busy && (st_q.pend != '0);
        chan_o    = sel;
        kind_o    = sel_data ? EV_DATA : EV_SIGNAL;
        payload_o = sel_data ? st_q.hold[PAY_W-1:0] : '0;
        clr_o     = '0;

        st_d = st_q;
        if (cfg_we_i && (int'(cfg_count_i) >= 1) && (int'(cfg_count_i) <= CHANNELS)) begin
            for (int i = 0; i < CHANNELS; i++) begin
                st_d.mask[i] = (i < int'(cfg_count_i));
            end
        end

        if (!st_q.busy) begin
            if (word_i != '0) begin
                st_d.busy = 1'b1;
                st_d.hold = word_i;
                for (int i = 0; i < CHANNELS; i++) begin
                    st_d.pend[i] = st_q.mask[i] &
                                   (word_i[WORD_W - 1 - i] | word_i[DAT_TOP - i]);
                end
            end
        end else if (st_q.pend != '0) begin
            if (ready_i) st_d.pend[sel] = 1'b0;
        end else begin
            clr_o     = st_q.hold;
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12: a stalled event holds its fields
    a_r12_hold_event: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(chan_o) && $stable(kind_o) && $stable(payload_o));

    // R6: every presented event is backed by a trigger bit of the captured word
    a_r6_event_backed: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (st_q.hold[WORD_W - 1 - int'(chan_o)] | st_q.hold[DAT_TOP - int'(chan_o)]));

    // R9: a clear only removes bits that are still present in the word
    a_r9_clear_is_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0) |-> (clr_o & ~word_i) == '0);

    // R8: enabled channels always form a run starting at channel 0
    a_r8_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mask + 1'b1) & st_q.mask) == '0);
endmodule

// File: rtl/ipc_mbox_top.sv
module ipc_mbox_top
    import ipc_mbox_pkg::*;
#(
    parameter int CHANNELS = 4,
    parameter int WORD_W   = 32,
    parameter int CIDX_W   = 3,
    localparam int PAY_W   = WORD_W - 2 * CHANNELS,
    localparam int CH_W    = $clog2(CHANNELS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCORE-1:0]                  send_valid,
    input  logic [NCORE-1:0][CIDX_W-1:0]      send_chan,
    input  logic [NCORE-1:0]                  send_data_mode,
    input  logic [NCORE-1:0][CIDX_W-1:0]      send_size,
    input  logic [NCORE-1:0][PAY_W-1:0]       send_payload,
    output logic [NCORE-1:0]                  send_done,
    output logic [NCORE-1:0][1:0]             send_status,
    input  logic [NCORE-1:0]                  cfg_we,
    input  logic [NCORE-1:0][CIDX_W-1:0]      cfg_rx_count,
    output logic [NCORE-1:0]                  rx_valid,
    input  logic [NCORE-1:0]                  rx_ready,
    output logic [NCORE-1:0][CH_W-1:0]        rx_chan,
    output logic [NCORE-1:0]                  rx_kind,
    output logic [NCORE-1:0][PAY_W-1:0]       rx_payload,
    output logic [NCORE-1:0][WORD_W-1:0]      word_rd,
    output logic [NCORE-1:0]                  irq
);
    logic [NCORE-1:0][WORD_W-1:0] set_w;
    logic [NCORE-1:0][WORD_W-1:0] clr_w;

    for (genvar k = 0; k < NCORE; k++) begin : g_core
        ipc_mbox_packer #(.CHANNELS(CHANNELS), .WORD_W(WORD_W), .CIDX_W(CIDX_W)) u_pack (
            .clk       (clk),
            .rst_n     (rst_n),
            .valid_i   (send_valid[k]),
            .chan_i    (send_chan[k]),
            .data_i    (send_data_mode[k]),
            .size_i    (send_size[k]),
            .payload_i (send_payload[k]),
            .set_o     (set_w[k]),
            .done_o    (send_done[k]),
            .status_o  (send_status[k])
        );

        ipc_mbox_word #(.WORD_W(WORD_W)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_w[NCORE - 1 - k]),
            .clr_i  (clr_w[k]),
            .word_o (word_rd[k])
        );

        ipc_mbox_rx #(.CHANNELS(CHANNELS), .WORD_W(WORD_W), .CIDX_W(CIDX_W)) u_rx (
            .clk         (clk),
            .rst_n       (rst_n),
            .word_i      (word_rd[k]),
            .cfg_we_i    (cfg_we[k]),
            .cfg_count_i (cfg_rx_count[k]),
            .ready_i     (rx_ready[k]),
            .valid_o     (rx_valid[k]),
            .chan_o      (rx_chan[k]),
            .kind_o      (rx_kind[k]),
            .payload_o   (rx_payload[k]),
            .clr_o       (clr_w[k])
        );

        assign irq[k] = |word_rd[k];

        // R5: an unconsumed event keeps the interrupt up
        a_r5_irq_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid[k] |-> irq[k]);
    end
endmodule

// File: tb/ipc_mbox_top_bench.sv
module ipc_mbox_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]        send_valid = '0;
    logic [1:0][2:0]   send_chan = '0;
    logic [1:0]        send_data_mode = '0;
    logic [1:0][2:0]   send_size = '0;
    logic [1:0][23:0]  send_payload = '0;
    logic [1:0]        send_done;
    logic [1:0][1:0]   send_status;
    logic [1:0]        cfg_we = '0;
    logic [1:0][2:0]   cfg_rx_count = '0;
    logic [1:0]        rx_valid;
    logic [1:0]        rx_ready = '0;
    logic [1:0][1:0]   rx_chan;
    logic [1:0]        rx_kind;
    logic [1:0][23:0]  rx_payload;
    logic [1:0][31:0]  word_rd;
    logic [1:0]        irq;

    ipc_mbox_top u_ipc_mbox_top (.*);

    int n_chk = 0;
    int n_err = 0;
    int cnt [2] = '{0, 0};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_status(int ch, bit dm, int sz);
        if (ch >= 4) return 2'd1;
        if (dm && sz != 3) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [31:0] exp_img(int ch, bit dm, logic [23:0] pl);
        if (dm) return (32'd1 << (27 - ch)) | {8'h0, pl};
        return 32'd1 << (31 - ch);
    endfunction

    task automatic send(int k, int ch, bit dm, int sz, logic [23:0] pl, string req);
        @(negedge clk);
        send_valid[k] = 1'b1; send_chan[k] = 3'(ch); send_data_mode[k] = dm;
        send_size[k] = 3'(sz); send_payload[k] = pl;
        @(negedge clk);
        send_valid[k] = 1'b0;
        check({req, " done"}, 32'(send_done[k]), 32'd1);
        check({req, " status"}, 32'(send_status[k]), 32'(exp_status(ch, dm, sz)));
    endtask

    task automatic config_rx(int k, int n);
        @(negedge clk);
        cfg_we[k] = 1'b1; cfg_rx_count[k] = 3'(n);
        @(negedge clk);
        cfg_we[k] = 1'b0;
        if (n >= 1 && n <= 4) cnt[k] = n;
    endtask

    task automatic expect_ev(int k, int ch, bit kind, logic [23:0] pl, string req);
        for (int i = 0; i < 20 && !rx_valid[k]; i++) @(negedge clk);
        check({req, " valid"}, 32'(rx_valid[k]), 32'd1);
        check({req, " chan"}, 32'(rx_chan[k]), 32'(ch));
        check({req, " kind"}, 32'(rx_kind[k]), 32'(kind));
        check({req, " payload"}, 32'(rx_payload[k]), 32'(pl));
        rx_ready[k] = 1'b1;
        @(negedge clk);
        rx_ready[k] = 1'b0;
    endtask

    task automatic expect_quiet(int k, string req);
        bit seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rx_valid[k]) seen = 1'b1;
        end
        check({req, " no event"}, 32'(seen), 32'd0);
        check({req, " word cleared"}, word_rd[k], 32'd0);
        check({req, " irq low"}, 32'(irq[k]), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] acc;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 word0", word_rd[0], 32'd0);
        check("R11 word1", word_rd[1], 32'd0);
        check("R11 irq", 32'(irq), 32'd0);
        check("R11 rx_valid", 32'(rx_valid), 32'd0);
        check("R11 send_done", 32'(send_done), 32'd0);

        // R8: no channel enabled after reset; R1 layout; R5 irq
        send(0, 0, 1'b0, 0, 24'h0, "R1 sig ch0");
        check("R1 peer word", word_rd[1], 32'h8000_0000);
        check("R5 irq high", 32'(irq[1]), 32'd1);
        check("R1 own word untouched", word_rd[0], 32'd0);
        expect_quiet(1, "R8 reset mask");

        // R8: valid counts, then ignored counts
        config_rx(0, 4);
        config_rx(1, 4);
        config_rx(1, 0);
        config_rx(1, 5);
        send(0, 3, 1'b0, 0, 24'h0, "R8 ignored count");
        expect_ev(1, 3, 1'b0, 24'h0, "R8 ch3 still enabled");
        expect_quiet(1, "R8 after ch3");

        // R2 data send from core1 to core0
        send(1, 2, 1'b1, 3, 24'hA5C3E1, "R2 data ch2");
        check("R2 peer word", word_rd[0], 32'h02A5_C3E1);
        expect_ev(0, 2, 1'b1, 24'hA5C3E1, "R2 data event");
        expect_quiet(0, "R2 after");

        // R3 / R4 directed rejections
        send(0, 4, 1'b0, 0, 24'h0, "R3 ch4");
        check("R3 no write", word_rd[1], 32'd0);
        send(0, 7, 1'b1, 3, 24'hFFFFFF, "R3 ch7");
        check("R3 no write ch7", word_rd[1], 32'd0);
        send(0, 1, 1'b1, 2, 24'h123456, "R4 size2");
        check("R4 no write", word_rd[1], 32'd0);
        send(0, 1, 1'b0, 6, 24'h0, "R4 signal ignores size");
        check("R4 signal written", word_rd[1], 32'h4000_0000);
        expect_ev(1, 1, 1'b0, 24'h0, "R4 signal event");
        expect_quiet(1, "R4 after");

        // R6 / R9 / R12: multi-channel word while receiver stalls
        send(0, 0, 1'b0, 0, 24'h0, "R9 first");
        for (int i = 0; i < 20 && !rx_valid[1]; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R12 held valid", 32'(rx_valid[1]), 32'd1);
        check("R12 held chan", 32'(rx_chan[1]), 32'd0);
        send(0, 2, 1'b1, 3, 24'h00F00F, "R6 data ch2");
        send(0, 2, 1'b0, 0, 24'h0, "R6 sig ch2");
        send(0, 1, 1'b0, 0, 24'h0, "R6 sig ch1");
        send(0, 3, 1'b1, 3, 24'h110000, "R6 data ch3");
        acc = 32'h8000_0000 | 32'h2000_0000 | 32'h4000_0000 | 32'h0200_0000 |
              32'h0100_0000 | 32'h0011_F00F;
        check("R9 accumulated word", word_rd[1], acc);
        check("R5 irq while pending", 32'(irq[1]), 32'd1);
        check("R12 still ch0", 32'(rx_chan[1]), 32'd0);
        expect_ev(1, 0, 1'b0, 24'h0, "R9 first event");
        @(negedge clk);
        check("R9 only seen bits cleared", word_rd[1], acc & ~32'h8000_0000);
        expect_ev(1, 1, 1'b0, 24'h0, "R6 order ch1");
        expect_ev(1, 2, 1'b1, 24'h11F00F, "R6 ch2 data wins");
        expect_ev(1, 3, 1'b1, 24'h11F00F, "R6 order ch3");
        expect_quiet(1, "R6 drained");

        // R10: send lands in the clear cycle
        send(0, 1, 1'b0, 0, 24'h0, "R10 first");
        for (int i = 0; i < 20 && !rx_valid[1]; i++) @(negedge clk);
        rx_ready[1] = 1'b1;
        @(negedge clk);
        rx_ready[1] = 1'b0;
        send_valid[0] = 1'b1; send_chan[0] = 3'd1; send_data_mode[0] = 1'b0;
        @(negedge clk);
        send_valid[0] = 1'b0;
        check("R10 set survives clear", word_rd[1], 32'h4000_0000);
        expect_ev(1, 1, 1'b0, 24'h0, "R10 re-reported");
        expect_quiet(1, "R10 after");

        // R7: disabled channels
        config_rx(1, 2);
        send(0, 3, 1'b0, 0, 24'h0, "R7 sig ch3");
        expect_quiet(1, "R7 ch3 masked");
        send(0, 2, 1'b1, 3, 24'h777777, "R7 data ch2");
        expect_quiet(1, "R7 ch2 masked");
        send(0, 1, 1'b1, 3, 24'h0ABCDE, "R7 ch1 enabled");
        expect_ev(1, 1, 1'b1, 24'h0ABCDE, "R7 ch1 event");
        expect_quiet(1, "R7 after");

        // random single sends
        for (int it = 0; it < 300; it++) begin
            int k, ch, sz, pk;
            bit dm;
            logic [23:0] pl;
            if (it % 25 == 0) begin
                config_rx(0, 1 + int'($urandom % 4));
                config_rx(1, 1 + int'($urandom % 4));
            end
            k  = int'($urandom % 2);
            pk = 1 - k;
            ch = int'($urandom % 6);
            dm = 1'($urandom % 2);
            sz = ($urandom % 4 == 0) ? int'($urandom % 8) : 3;
            pl = 24'($urandom);
            send(k, ch, dm, sz, pl, "R1 R2 R3 R4 random");
            if (exp_status(ch, dm, sz) != 2'd0) begin
                check("R3 R4 random no write", word_rd[pk], 32'd0);
            end else begin
                check("R1 R2 random word", word_rd[pk], exp_img(ch, dm, pl));
                if (ch < cnt[pk]) expect_ev(pk, ch, dm, dm ? pl : 24'h0, "R6 random event");
                else              expect_quiet(pk, "R7 random masked");
            end
            expect_quiet(pk, "R9 random drained");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule